// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock and the bit-phase strobes for a fast-mode I2C master. A sequencer issues one bit-level command at a time (START, STOP, BIT or RESTART). The generator plays out the matching phases and marks four points for the data path: where to drive SDA, where to sample SDA, and where the START or STOP condition happens. It pulses `done_o` in the last cycle of the command.

Every duration comes from a static configuration input. An 8-bit prescaler turns the input clock into ticks. Each phase count is measured in those ticks, and a phase of value N lasts N+1 ticks. Each SCL edge adds a fixed overhead of 4 input clocks plus the glitch-filter cycle count. The bit period is therefore built from several programmable pieces rather than a single divide-by-N toggle.

Top module: `i2c_scl_timing`

## Requirements
- R1: After reset the generator is idle. `scl_drive_o` is 0 (SCL released), `cmd_ready_o` is 1, and `sda_launch_o`, `sda_sample_o`, `start_stb_o`, `stop_stb_o` and `done_o` are 0.
- R2: A BIT command is busy for (D+1)*(Le+H+2) + 8 + 2*F input clocks. Here D is `clk_div_i` (0..255, a divide ratio of 1..256), H is `scl_hi_i`, F is `flt_cyc_i`, and Le is the effective low count. During the first (D+1)*(Le+1)+4+F of those clocks `scl_drive_o` is 1, and during the rest it is 0.
- R3: The effective low count Le is the larger of `scl_lo_i` and `dat_hd_i + dat_su_i + 1`. The low phase is stretched when the SDA hold plus setup would not fit.
- R4: In BIT, STOP and RESTART, `sda_launch_o` pulses once, `dat_hd_i`*(D+1) clocks after the first low cycle. It pulses only while `scl_drive_o` is 1.
- R5: In BIT, `sda_sample_o` pulses once, in the first cycle of the high phase. That cycle is the first one with `scl_drive_o` 0, and the pulse happens only while SCL is released.
- R6: START keeps SCL released for (`sta_su_i`+1)*(D+1) clocks. `start_stb_o` pulses in the last of those clocks. The hold then lasts (`sta_hd_i`+1)*(D+1) clocks, and then the command ends.
- R7: STOP holds SCL low for (D+1)*(Le+1)+4+F clocks and then releases it for (`sto_su_i`+1)*(D+1) clocks. `stop_stb_o` pulses together with `done_o` in the last cycle. Afterwards SCL stays released while idle.
- R8: RESTART holds SCL low like STOP and then releases it for (`rs_rel_i`+1)*(D+1) clocks. `start_stb_o` pulses in the last of those clocks, followed by a START hold of (`sta_hd_i`+1)*(D+1) clocks.
- R9: The `cmd_op_i` encoding is 0 START, 1 STOP, 2 BIT, 3 RESTART. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low from the next cycle until the command ends, and `cmd_valid_i` has no effect during that time. `done_o` is a single pulse in the last busy cycle, and `cmd_ready_o` is 1 in the cycle after it.
- R10: After a START, BIT or RESTART ends, `scl_drive_o` stays 1 while idle. The bus stays parked low until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_div_i | input | 8 | Prescaler value D, tick every D+1 clocks |
| scl_lo_i | input | 8 | SCL low count |
| scl_hi_i | input | 8 | SCL high count |
| sta_su_i | input | 8 | START setup count |
| sta_hd_i | input | 8 | START hold count |
| sto_su_i | input | 8 | STOP setup count |
| dat_su_i | input | 8 | SDA setup count |
| dat_hd_i | input | 8 | SDA hold count |
| rs_rel_i | input | 8 | Repeated-start release count |
| flt_cyc_i | input | 3 | Glitch-filter cycle count |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | Command: 0 START, 1 STOP, 2 BIT, 3 RESTART |
| cmd_ready_o | output | 1 | Generator idle, command can be taken |
| scl_drive_o | output | 1 | 1 pulls SCL low |
| sda_launch_o | output | 1 | Point to change SDA |
| sda_sample_o | output | 1 | Point to sample SDA |
| start_stb_o | output | 1 | START condition point |
| stop_stb_o | output | 1 | STOP condition point |
| done_o | output | 1 | Command complete |

## Verification
The checker module enforces the relations that hold in every cycle. Launch pulses come only while SCL is held low, and sample pulses only while it is released. A START strobe never coincides with a STOP strobe, and `done_o` only occurs while busy. The cycle after `done_o` is ready, and the cycle after a STOP strobe has SCL released. The exact cycle counts cannot be seen from single-cycle relations, so only the bench scenarios show them. These counts cover the busy length, the low length with its stretch, the offsets of the launch, sample and condition strobes, and the parking of SCL between commands. The bench checks them against values computed from the configuration, over random configurations and command sequences, and with a prescaler at its maximum.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_STOP    = 2'd1,
    OP_BIT     = 2'd2,
    OP_RESTART = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_SU, S_ST_HD, S_LOW, S_LOW_OVH,
    S_HIGH, S_HIGH_OVH, S_SP_SU, S_RS_REL
  } st_e;

  localparam int unsigned EDGE_OVH = 4;
endpackage

// File: rtl/i2c_tg_prescale.sv
module i2c_tg_prescale #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o,
  output logic         first_o
);
  logic [W-1:0] pre_q;

  assign tick_o  = (pre_q == div_i);
  assign first_o = (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i || tick_o)   pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/i2c_tg_phase_cnt.sv
module i2c_tg_phase_cnt #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] tgt_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign last_o = step_i && (cnt_q == tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
  import i2c_tg_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned FLT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] clk_div_i,
  input  logic [CNT_W-1:0] scl_lo_i,
  input  logic [CNT_W-1:0] scl_hi_i,
  input  logic [CNT_W-1:0] sta_su_i,
  input  logic [CNT_W-1:0] sta_hd_i,
  input  logic [CNT_W-1:0] sto_su_i,
  input  logic [CNT_W-1:0] dat_su_i,
  input  logic [CNT_W-1:0] dat_hd_i,
  input  logic [CNT_W-1:0] rs_rel_i,
  input  logic [FLT_W-1:0] flt_cyc_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  output logic             cmd_ready_o,
  output logic             scl_drive_o,
  output logic             sda_launch_o,
  output logic             sda_sample_o,
  output logic             start_stb_o,
  output logic             stop_stb_o,
  output logic             done_o
);
  localparam int unsigned PW = CNT_W + 1;

  st_e         st_q, st_d;
  op_e         op_q;
  logic        park_q;
  logic        tick, first, step, last, clr;
  logic [PW-1:0] tgt, ph_cnt, lo_need, lo_eff, ovh_tgt;

  // low phase stretched so SDA hold + setup fit inside it
  assign lo_need = PW'(dat_hd_i) + PW'(dat_su_i) + PW'(1);
  assign lo_eff  = (lo_need > PW'(scl_lo_i)) ? lo_need : PW'(scl_lo_i);
  assign ovh_tgt = PW'(EDGE_OVH - 1) + PW'(flt_cyc_i);

  always_comb begin
    tgt  = '0;
    step = tick;
    unique case (st_q)
      S_ST_SU:    tgt = PW'(sta_su_i);
      S_ST_HD:    tgt = PW'(sta_hd_i);
      S_LOW:      tgt = lo_eff;
      S_HIGH:     tgt = PW'(scl_hi_i);
      S_SP_SU:    tgt = PW'(sto_su_i);
      S_RS_REL:   tgt = PW'(rs_rel_i);
      S_LOW_OVH, S_HIGH_OVH: begin
        tgt  = ovh_tgt;
        step = 1'b1;
      end
      default:    tgt = '0;
    endcase
  end

  assign clr = (st_q == S_IDLE) || last;

  i2c_tg_prescale #(.W(CNT_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(clr), .div_i(clk_div_i),
    .tick_o(tick), .first_o(first)
  );

  i2c_tg_phase_cnt #(.W(PW)) u_ph (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step), .tgt_i(tgt),
    .cnt_o(ph_cnt), .last_o(last)
  );

  always_comb begin
    st_d = st_q;
    if (st_q == S_IDLE) begin
      if (cmd_valid_i) st_d = (op_e'(cmd_op_i) == OP_START) ? S_ST_SU : S_LOW;
    end else if (last) begin
      unique case (st_q)
        S_ST_SU:    st_d = S_ST_HD;
        S_RS_REL:   st_d = S_ST_HD;
        S_LOW:      st_d = S_LOW_OVH;
        S_HIGH:     st_d = S_HIGH_OVH;
        S_LOW_OVH: begin
          unique case (op_q)
            OP_STOP:    st_d = S_SP_SU;
            OP_RESTART: st_d = S_RS_REL;
            default:    st_d = S_HIGH;
          endcase
        end
        default:    st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= OP_START;
      park_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && cmd_valid_i) op_q <= op_e'(cmd_op_i);
      if (done_o) park_q <= (op_q != OP_STOP);
    end
  end

  assign cmd_ready_o  = (st_q == S_IDLE);
  assign scl_drive_o  = (st_q == S_LOW) || (st_q == S_LOW_OVH) ||
                        ((st_q == S_IDLE) && park_q);
  assign sda_launch_o = (st_q == S_LOW) && first && (ph_cnt == PW'(dat_hd_i));
  assign sda_sample_o = (st_q == S_HIGH) && first && (ph_cnt == '0);
  assign start_stb_o  = last && ((st_q == S_ST_SU) || (st_q == S_RS_REL));
  assign done_o       = last && ((st_q == S_ST_HD) || (st_q == S_HIGH_OVH) ||
                                 (st_q == S_SP_SU));
  assign stop_stb_o   = last && (st_q == S_SP_SU);
endmodule

// File: rtl/i2c_scl_timing_chk.sv
module i2c_scl_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ready_o,
  input logic scl_drive_o,
  input logic sda_launch_o,
  input logic sda_sample_o,
  input logic start_stb_o,
  input logic stop_stb_o,
  input logic done_o
);
  // R4
  launch_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_launch_o |-> scl_drive_o);
  // R5
  sample_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_sample_o |-> !scl_drive_o);
  // R6
  cond_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_stb_o && stop_stb_o));
  // R9
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_ready_o);
  // R9
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cmd_ready_o);
  // R7
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_stb_o |=> !scl_drive_o);
  // R7
  stop_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_stb_o |-> done_o);
endmodule

bind i2c_scl_timing i2c_scl_timing_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o),
  .scl_drive_o(scl_drive_o), .sda_launch_o(sda_launch_o),
  .sda_sample_o(sda_sample_o), .start_stb_o(start_stb_o),
  .stop_stb_o(stop_stb_o), .done_o(done_o)
);

// File: tb/test_i2c_scl_timing.sv
module test_i2c_scl_timing;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] clk_div_i, scl_lo_i, scl_hi_i, sta_su_i, sta_hd_i, sto_su_i;
  logic [7:0] dat_su_i, dat_hd_i, rs_rel_i;
  logic [2:0] flt_cyc_i;
  logic       cmd_valid_i;
  logic [1:0] cmd_op_i;
  logic cmd_ready_o, scl_drive_o, sda_launch_o, sda_sample_o;
  logic start_stb_o, stop_stb_o, done_o;

  int tests = 0, fails = 0, cyc = 0;
  bit done_run = 0;

  always #10 clk_i = ~clk_i;

  i2c_scl_timing i_i2c_scl_timing (.*);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done_run) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int lo_eff();
    int need = int'(dat_hd_i) + int'(dat_su_i) + 1;
    return (need > int'(scl_lo_i)) ? need : int'(scl_lo_i);
  endfunction
  function automatic int tk(input int n);
    return (n + 1) * (int'(clk_div_i) + 1);
  endfunction
  function automatic int low_len();
    return tk(lo_eff()) + 4 + int'(flt_cyc_i);
  endfunction

  task automatic run_cmd(input int op, input bit inject);
    int busy = 0, low = 0, l_i = 0, l_n = 0, s_i = 0, s_n = 0;
    int st_i = 0, sp_i = 0, d_i = 0, d_n = 0;
    int e_busy, e_low, e_st, e_sp, e_s;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'(op);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    forever begin
      if (cmd_ready_o || busy > 20000) break;
      busy++;
      if (scl_drive_o) low++;
      if (sda_launch_o) begin l_n++; if (l_i == 0) l_i = busy; end
      if (sda_sample_o) begin s_n++; if (s_i == 0) s_i = busy; end
      if (start_stb_o && st_i == 0) st_i = busy;
      if (stop_stb_o && sp_i == 0) sp_i = busy;
      if (done_o) begin d_n++; d_i = busy; cmd_valid_i = 1'b0; end
      else if (inject && busy == 2) begin cmd_valid_i = 1'b1; cmd_op_i = 2'd0; end
      @(negedge clk_i);
    end
    e_low = 0; e_st = 0; e_sp = 0; e_s = 0;
    case (op)
      0: begin e_st = tk(sta_su_i); e_busy = e_st + tk(sta_hd_i); end
      1: begin e_low = low_len(); e_busy = e_low + tk(sto_su_i); e_sp = e_busy; end
      2: begin e_low = low_len(); e_s = e_low + 1;
               e_busy = e_low + tk(scl_hi_i) + 4 + int'(flt_cyc_i); end
      default: begin e_low = low_len(); e_st = e_low + tk(rs_rel_i);
               e_busy = e_st + tk(sta_hd_i); end
    endcase
    case (op)
      0: check("R6 start busy", busy, e_busy);
      1: check("R7 stop busy", busy, e_busy);
      2: check("R2 bit period", busy, e_busy);
      default: check("R8 restart busy", busy, e_busy);
    endcase
    check(op == 2 ? "R2 low length" : "R3 low length", low, e_low);
    check("R9 done idx", d_i, e_busy);
    check("R9 done single", d_n, 1);
    check("R6 R8 start strobe idx", st_i, e_st);
    check("R7 stop strobe idx", sp_i, e_sp);
    check("R5 sample idx", s_i, e_s);
    check("R5 sample count", s_n, (op == 2) ? 1 : 0);
    check("R4 launch count", l_n, (op == 0) ? 0 : 1);
    if (op != 0) check("R4 launch idx", l_i, int'(dat_hd_i) * (int'(clk_div_i) + 1) + 1);
    check("R9 ready after done", int'(cmd_ready_o), 1);
    check(op == 1 ? "R7 released idle" : "R10 parked low", int'(scl_drive_o), (op == 1) ? 0 : 1);
    if (inject) begin
      @(negedge clk_i);
      check("R9 ignored while busy", int'(cmd_ready_o), 1);
      check("R10 idle scl stable", int'(scl_drive_o), (op == 1) ? 0 : 1);
    end
  endtask

  task automatic rand_cfg();
    clk_div_i = 8'($urandom_range(0, 3));
    scl_lo_i  = 8'($urandom_range(0, 20));
    scl_hi_i  = 8'($urandom_range(0, 20));
    sta_su_i  = 8'($urandom_range(0, 10));
    sta_hd_i  = 8'($urandom_range(0, 10));
    sto_su_i  = 8'($urandom_range(0, 10));
    dat_su_i  = 8'($urandom_range(0, 6));
    dat_hd_i  = 8'($urandom_range(0, 6));
    rs_rel_i  = 8'($urandom_range(0, 10));
    flt_cyc_i = 3'($urandom_range(0, 7));
  endtask

  initial begin
    void'($urandom(32'd1234));
    cmd_valid_i = 0; cmd_op_i = 0;
    rand_cfg();
    #45 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check("R1 reset scl", int'(scl_drive_o), 0);
    check("R1 reset ready", int'(cmd_ready_o), 1);
    check("R1 reset strobes", int'({sda_launch_o, sda_sample_o, start_stb_o, stop_stb_o, done_o}), 0);

    // directed: R3 stretch (hold+setup exceed low count)
    clk_div_i = 8'd1; scl_lo_i = 8'd2; dat_hd_i = 8'd3; dat_su_i = 8'd2;
    run_cmd(0, 1'b0); run_cmd(2, 1'b1); run_cmd(1, 1'b1);
    // directed: max prescaler, zero counts, max filter
    clk_div_i = 8'd255; scl_lo_i = 0; scl_hi_i = 0; dat_hd_i = 0; dat_su_i = 0;
    sta_su_i = 0; sta_hd_i = 0; sto_su_i = 0; rs_rel_i = 0; flt_cyc_i = 3'd7;
    run_cmd(0, 1'b0); run_cmd(2, 1'b0); run_cmd(3, 1'b0); run_cmd(1, 1'b0);

    for (int it = 0; it < 30; it++) begin
      rand_cfg();
      run_cmd(0, 1'b0);
      for (int b = 0; b < 3; b++) run_cmd(2, ($urandom_range(0, 1) == 1));
      if ($urandom_range(0, 1) == 1) begin
        run_cmd(3, 1'b1);
        run_cmd(2, 1'b0);
      end
      run_cmd(1, ($urandom_range(0, 1) == 1));
    end
    done_run = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule